// File: doc/BRIEF.md
# Programmable dual-modulus feedback divider

This block is the feedback divider of a PLL. It produces one single-cycle pulse for every N cycles of its input clock. A 3-bit mode code picks the prescaler. The prescaler is either a fixed divide of 1, 2 or 3, or a dual-modulus pair P/P+1 with P from 2 up to 32. A swallow count A and a main count B complete the ratio. In dual-modulus mode the ratio is N = P×B + A. In fixed-divide mode the ratio is N = P×B.

A bypass input forces the main count to 1. This is legal only with a fixed-divide prescaler, so it lets N go down to 1. The block checks the programmed setting all the time and raises a flag when the setting cannot be used. While the loaded setting is illegal, the divider stays idle.

Settings are taken in only at a frame boundary, so a frame that is running always completes. Two clear inputs exist: one shared with the reference counter and one private to the A/B pair. Either clear returns the counters to their start state.

Top module: `fbdiv_top`

## Requirements
- R1: The mode code decodes as follows. 3'b000 is fixed ÷1, 3'b001 is fixed ÷2 and 3'b111 is fixed ÷3. 3'b010, 3'b011, 3'b100, 3'b101 and 3'b110 are dual-modulus with P = 2, 4, 8, 16 and 32.
- R2: In dual-modulus mode, each frame lasts P×B + A input cycles. The first A prescaler periods of a frame last P+1 cycles each and the remaining B−A periods last P cycles each. Any two settings with the same N give the same pulse spacing.
- R3: In fixed-divide mode the swallow input has no effect, and the frame lasts P×B cycles.
- R4: With bypass set and a fixed-divide mode, B is taken as 1 whatever the main input holds. Bypass combined with a dual-modulus mode is invalid.
- R5: Without bypass, B must lie in 3..8191. A value of 0, 1 or 2 is invalid, and 0 is the value the main input has after reset.
- R6: In dual-modulus mode, a swallow count larger than B is invalid.
- R7: `invalid_o` follows the live inputs in the same cycle. While the loaded setting is invalid, `pulse_o` stays low.
- R8: `pulse_o` is high for exactly one cycle per frame. After a clear is released, the first pulse appears N+1 clock edges later, and each following pulse comes N cycles after the one before.
- R9: A setting changed in the middle of a frame takes effect only after that frame ends. The running frame keeps its old length.
- R10: Raising either `clr_all_i` or `clr_ab_i` suppresses the pulse at the next edge and restarts the frame from its first cycle.
- R11: Fixed ÷1 with bypass gives a pulse on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to divide |
| rst_i | input | 1 | Synchronous reset, active high |
| clr_all_i | input | 1 | Clear shared with the reference counter |
| clr_ab_i | input | 1 | Clear private to the A/B counters |
| mode_i | input | 3 | Prescaler mode code |
| swallow_i | input | A_W | Swallow count A |
| main_i | input | B_W | Main count B |
| bypass_i | input | 1 | Forces B = 1 |
| pulse_o | output | 1 | One-cycle pulse per frame |
| invalid_o | output | 1 | Current input setting is illegal |

## Verification
The hardest situation to reach from the ports is a setting change that lands inside a running frame. To reach it, the stimulus must know the frame phase. The bench restarts the divider with a clear, counts cycles from the release, and changes the setting a few cycles after a known pulse. It then checks that the next pulse still comes at the old spacing and that the new spacing starts after it. Random legal settings are each restarted by a clear and measured over three frames. This exercises the swallow and main counts at their unequal and equal extremes.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;

    localparam int PW = 6;

    typedef struct packed {
        logic          dual;
        logic [PW-1:0] p;
    } psc_t;

    function automatic psc_t decode_mode(input logic [2:0] code);
        psc_t r;
        r.dual = 1'b0;
        r.p    = PW'(1);
        case (code)
            3'b000: begin r.dual = 1'b0; r.p = PW'(1);  end
            3'b001: begin r.dual = 1'b0; r.p = PW'(2);  end
            3'b111: begin r.dual = 1'b0; r.p = PW'(3);  end
            3'b010: begin r.dual = 1'b1; r.p = PW'(2);  end
            3'b011: begin r.dual = 1'b1; r.p = PW'(4);  end
            3'b100: begin r.dual = 1'b1; r.p = PW'(8);  end
            3'b101: begin r.dual = 1'b1; r.p = PW'(16); end
            default: begin r.dual = 1'b1; r.p = PW'(32); end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fbdiv_decode.sv
module fbdiv_decode
    import fbdiv_pkg::*;
#(
    parameter int A_W = 6,
    parameter int B_W = 13
) (
    input  logic [2:0]     mode_i,
    input  logic [A_W-1:0] swallow_i,
    input  logic [B_W-1:0] main_i,
    input  logic           bypass_i,
    output logic           dual_o,
    output logic [PW-1:0]  p_o,
    output logic [A_W-1:0] a_eff_o,
    output logic [B_W-1:0] b_eff_o,
    output logic           bad_o
);
    localparam logic [B_W-1:0] B_MIN = B_W'(3);

    psc_t           psc;
    logic [B_W-1:0] a_wide;

    always_comb begin
        psc     = decode_mode(mode_i);
        a_wide  = {{(B_W-A_W){1'b0}}, swallow_i};
        dual_o  = psc.dual;
        p_o     = psc.p;
        a_eff_o = psc.dual ? swallow_i : '0;
        b_eff_o = bypass_i ? B_W'(1) : main_i;
        bad_o   = 1'b0;
        if (psc.dual && bypass_i)          bad_o = 1'b1;
        if (!bypass_i && main_i < B_MIN)   bad_o = 1'b1;
        if (psc.dual && a_wide > main_i)   bad_o = 1'b1;
    end

    always_comb begin
        if (bypass_i && !psc.dual) begin
            AST_BYP_UNITY: assert (b_eff_o == B_W'(1) && !bad_o); // R4
        end
    end

endmodule

// File: rtl/fbdiv_prescale.sv
module fbdiv_prescale
    import fbdiv_pkg::*;
(
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          hold_i,
    input  logic          plus1_i,
    input  logic [PW-1:0] p_i,
    output logic          tick_o
);
    typedef struct packed {
        logic [PW-1:0] pc;
    } ps_st_t;

    ps_st_t        st_d, st_q;
    logic [PW-1:0] div;

    always_comb begin
        div    = p_i + PW'(plus1_i);
        tick_o = !hold_i && (st_q.pc == div - PW'(1));
        st_d   = st_q;
        if (hold_i || tick_o) st_d.pc = '0;
        else                  st_d.pc = st_q.pc + PW'(1);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    AST_PC_IN_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
        !hold_i |-> st_q.pc < div); // R2

endmodule

// File: rtl/fbdiv_frame.sv
module fbdiv_frame
    import fbdiv_pkg::*;
#(
    parameter int A_W = 6,
    parameter int B_W = 13
) (
    input  logic           clk_i,
    input  logic           rst_i,
    input  logic           clr_i,
    input  logic           dual_i,
    input  logic [PW-1:0]  p_i,
    input  logic [A_W-1:0] a_i,
    input  logic [B_W-1:0] b_i,
    input  logic           bad_i,
    input  logic           tick_i,
    output logic           run_o,
    output logic           plus1_o,
    output logic [PW-1:0]  p_o,
    output logic           frame_end_o
);
    typedef struct packed {
        logic           run;
        logic           dual;
        logic [PW-1:0]  p;
        logic [A_W-1:0] a;
        logic [B_W-1:0] b;
        logic [A_W-1:0] acnt;
        logic [B_W-1:0] bcnt;
    } fr_st_t;

    fr_st_t st_d, st_q;

    always_comb begin
        run_o       = st_q.run;
        p_o         = st_q.p;
        plus1_o     = st_q.run && st_q.dual && (st_q.acnt < st_q.a);
        frame_end_o = !clr_i && st_q.run && tick_i && (st_q.bcnt == st_q.b - B_W'(1));
        st_d        = st_q;
        if (clr_i) begin
            st_d.run  = 1'b0;
            st_d.acnt = '0;
            st_d.bcnt = '0;
        end else if (!st_q.run || frame_end_o) begin
            st_d.run  = !bad_i;
            st_d.dual = dual_i;
            st_d.p    = p_i;
            st_d.a    = a_i;
            st_d.b    = b_i;
            st_d.acnt = '0;
            st_d.bcnt = '0;
        end else if (tick_i) begin
            st_d.bcnt = st_q.bcnt + B_W'(1);
            if (st_q.acnt < st_q.a) st_d.acnt = st_q.acnt + A_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    AST_SWALLOW_TRAILS: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.run |-> {{(B_W-A_W){1'b0}}, st_q.acnt} <= st_q.bcnt); // R2
    AST_FD_NO_SWALLOW: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q.run && !st_q.dual) |-> st_q.acnt == '0); // R3
    AST_BYP_FD_ONLY: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q.run && st_q.b == B_W'(1)) |-> !st_q.dual); // R4
    AST_MAIN_BOUND: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.run |-> st_q.bcnt < st_q.b); // R8

endmodule

// File: rtl/fbdiv_top.sv
module fbdiv_top
    import fbdiv_pkg::*;
#(
    parameter int A_W = 6,
    parameter int B_W = 13
) (
    input  logic           clk_i,
    input  logic           rst_i,
    input  logic           clr_all_i,
    input  logic           clr_ab_i,
    input  logic [2:0]     mode_i,
    input  logic [A_W-1:0] swallow_i,
    input  logic [B_W-1:0] main_i,
    input  logic           bypass_i,
    output logic           pulse_o,
    output logic           invalid_o
);
    typedef struct packed {
        logic pulse;
    } top_st_t;

    logic           dec_dual, dec_bad, clr, run, plus1, tick, frame_end;
    logic [PW-1:0]  dec_p, cur_p;
    logic [A_W-1:0] dec_a;
    logic [B_W-1:0] dec_b;
    top_st_t        st_d, st_q;

    fbdiv_decode #(.A_W(A_W), .B_W(B_W)) u_dec (
        .mode_i    (mode_i),
        .swallow_i (swallow_i),
        .main_i    (main_i),
        .bypass_i  (bypass_i),
        .dual_o    (dec_dual),
        .p_o       (dec_p),
        .a_eff_o   (dec_a),
        .b_eff_o   (dec_b),
        .bad_o     (dec_bad)
    );

    fbdiv_prescale u_psc (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .hold_i  (clr || !run),
        .plus1_i (plus1),
        .p_i     (cur_p),
        .tick_o  (tick)
    );

    fbdiv_frame #(.A_W(A_W), .B_W(B_W)) u_frm (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .clr_i       (clr),
        .dual_i      (dec_dual),
        .p_i         (dec_p),
        .a_i         (dec_a),
        .b_i         (dec_b),
        .bad_i       (dec_bad),
        .tick_i      (tick),
        .run_o       (run),
        .plus1_o     (plus1),
        .p_o         (cur_p),
        .frame_end_o (frame_end)
    );

    always_comb begin
        clr        = clr_all_i || clr_ab_i;
        st_d.pulse = frame_end;
        pulse_o    = st_q.pulse;
        invalid_o  = dec_bad;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
        !run |=> !pulse_o); // R7
    AST_CLR_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
        (clr_all_i || clr_ab_i) |=> !pulse_o); // R10

endmodule

// File: tb/sim_fbdiv_top.sv
module sim_fbdiv_top;
    localparam int A_W = 6;
    localparam int B_W = 13;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           clr_all = 1'b0, clr_ab = 1'b0;
    logic [2:0]     mode = 3'b000;
    logic [A_W-1:0] sw = '0;
    logic [B_W-1:0] mb = '0;
    logic           byp = 1'b0;
    logic           pulse, inval;
    int             total = 0, bad = 0;
    bit             done = 1'b0;

    always #4 clk = ~clk;

    fbdiv_top #(.A_W(A_W), .B_W(B_W)) u0 (
        .clk_i(clk), .rst_i(rst), .clr_all_i(clr_all), .clr_ab_i(clr_ab),
        .mode_i(mode), .swallow_i(sw), .main_i(mb), .bypass_i(byp),
        .pulse_o(pulse), .invalid_o(inval)
    );

    function automatic int ref_p(input logic [2:0] m);
        case (m)
            3'b000: return 1;  3'b001: return 2;  3'b111: return 3;
            3'b010: return 2;  3'b011: return 4;  3'b100: return 8;
            3'b101: return 16; default: return 32;
        endcase
    endfunction

    function automatic bit ref_dual(input logic [2:0] m);
        return !(m == 3'b000 || m == 3'b001 || m == 3'b111);
    endfunction

    function automatic bit ref_bad(input logic [2:0] m, input int a, input int b, input bit y);
        if (ref_dual(m) && y) return 1'b1;
        if (!y && b < 3) return 1'b1;
        if (ref_dual(m) && a > b) return 1'b1;
        return 1'b0;
    endfunction

    function automatic int ref_n(input logic [2:0] m, input int a, input int b, input bit y);
        int be = y ? 1 : b;
        return ref_dual(m) ? ref_p(m) * be + a : ref_p(m) * be;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_cfg(input logic [2:0] m, input int a, input int b, input bit y,
                           input bit use_all, input string req);
        bit eb = ref_bad(m, a, b, y);
        int n  = ref_n(m, a, b, y);
        int first_bad_k = -1, act = 0, exp = 0;
        @(negedge clk);
        mode = m; sw = A_W'(a); mb = B_W'(b); byp = y;
        if (use_all) clr_all = 1'b1; else clr_ab = 1'b1;
        @(negedge clk);
        check(pulse == 1'b0, "R10 pulse after clear", int'(pulse), 0);
        clr_all = 1'b0; clr_ab = 1'b0;
        #1;
        check(inval == eb, {req, " flag"}, int'(inval), int'(eb));
        if (eb) begin
            for (int k = 1; k <= 40; k++) begin
                @(negedge clk);
                if (pulse && first_bad_k < 0) first_bad_k = k;
            end
            check(first_bad_k < 0, "R7 no pulse when invalid", first_bad_k, -1);
        end else begin
            for (int k = 1; k <= 3 * n + 1; k++) begin
                bit e;
                @(negedge clk);
                e = (k > n) && ((k - 1) % n == 0);
                if (pulse != e && first_bad_k < 0) begin
                    first_bad_k = k; act = int'(pulse); exp = int'(e);
                end
            end
            if (first_bad_k >= 0)
                $display("  at cycle %0d of setting N=%0d", first_bad_k, n);
            check(first_bad_k < 0, {req, " R8 spacing"}, act, exp);
        end
    endtask

    initial begin
        int watch = 0;
        while (!done && watch < 190000) begin
            @(posedge clk);
            watch++;
        end
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=0", watch);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int miss;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        #1;
        check(pulse == 1'b0, "R8 reset pulse", int'(pulse), 0);
        check(inval == 1'b1, "R5 reset main=0 invalid", int'(inval), 1);
        rst = 1'b0;
        miss = 0;
        repeat (20) begin
            @(negedge clk);
            if (pulse) miss++;
        end
        check(miss == 0, "R7 idle after reset", miss, 0);

        run_cfg(3'b000, 0, 0, 1'b1, 1'b0, "R11 div1 bypass");
        run_cfg(3'b001, 0, 0, 1'b1, 1'b1, "R4 div2 bypass");
        run_cfg(3'b111, 0, 5, 1'b0, 1'b0, "R1 div3 B=5");
        run_cfg(3'b001, 63, 4, 1'b0, 1'b1, "R3 swallow ignored");
        run_cfg(3'b010, 1, 3, 1'b0, 1'b0, "R2 2/3 A1 B3");
        run_cfg(3'b011, 1, 3, 1'b0, 1'b0, "R2 4/5 A1 B3");
        run_cfg(3'b001, 0, 6, 1'b0, 1'b1, "R2 N12 fd");
        run_cfg(3'b010, 0, 6, 1'b0, 1'b0, "R2 N12 2/3");
        run_cfg(3'b011, 0, 3, 1'b0, 1'b1, "R2 N12 4/5");
        run_cfg(3'b110, 5, 6, 1'b0, 1'b0, "R1 32/33");
        run_cfg(3'b100, 4, 4, 1'b0, 1'b0, "R2 A equals B");
        run_cfg(3'b101, 2, 3, 1'b0, 1'b1, "R1 16/17");
        run_cfg(3'b001, 0, 2, 1'b0, 1'b0, "R5 B=2");
        run_cfg(3'b000, 0, 0, 1'b0, 1'b1, "R5 B=0");
        run_cfg(3'b010, 0, 3, 1'b1, 1'b0, "R4 bypass with dual");
        run_cfg(3'b010, 5, 3, 1'b0, 1'b1, "R6 A over B");

        @(negedge clk);
        mode = 3'b011; sw = 6'd1; mb = 13'd8191; byp = 1'b0;
        #1;
        check(inval == 1'b0, "R5 B=8191 legal", int'(inval), 0);
        mb = 13'd3;
        #1;
        check(inval == 1'b0, "R5 B=3 legal", int'(inval), 0);

        for (int i = 0; i < 25; i++) begin
            logic [2:0] m = 3'($urandom_range(0, 7));
            int  b = $urandom_range(3, 20);
            int  a = ref_dual(m) ? $urandom_range(0, b) : $urandom_range(0, 63);
            bit  y = !ref_dual(m) && ($urandom_range(0, 3) == 0);
            run_cfg(m, a, b, y, bit'(i % 2), "R2 random");
        end

        begin
            int first_bad_k = -1, act = 0, exp = 0;
            @(negedge clk);
            mode = 3'b001; sw = '0; mb = 13'd3; byp = 1'b0; clr_ab = 1'b1;
            @(negedge clk);
            clr_ab = 1'b0;
            for (int k = 1; k <= 30; k++) begin
                bit e;
                @(negedge clk);
                e = (k == 7 || k == 13 || k == 17 || k == 21 || k == 25 || k == 29);
                if (pulse != e && first_bad_k < 0) begin
                    first_bad_k = k; act = int'(pulse); exp = int'(e);
                end
                if (k == 9) begin mode = 3'b000; mb = 13'd4; end
            end
            check(first_bad_k < 0, "R9 change at frame boundary", act, exp);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule